// File: doc/BRIEF.md
# Duplicated-Path Self-Checking Pipeline Stage

This block is one stage of a handshake-driven micropipeline whose datapath is carried twice. Two copies of each data word reach the stage: a primary word and its duplicate. Every bit is held by a two-input Muller C-element. A C-element copies its inputs when the two inputs agree and keeps its previous value when they disagree, so a disagreement on one copy is never passed on as a changed output bit. A word-wide equality check drives the control. When every bit pair agrees, the stage commits the word to a storage model that keeps its contents through power loss, and it then acknowledges. When any pair disagrees, the stage writes nothing, withholds the acknowledge and sends a re-read pulse back to the previous stage. That pulse makes the previous stage present its stored word again, so the logic between the stages evaluates once more.

The storage is never cleared. When reset or power-down is applied, the volatile C-element outputs go to zero and the control returns to its off state. When the input is released, the stage spends one cycle sensing its storage and reloads the C-elements from it. A protect enable, for the shunt path around the storage cells, is active only in standby, when the stage is neither reading nor writing. A saturating counter records how many re-read events have occurred.

Top module: `nvstage_top`

## Requirements
- R1: While the stage is evaluating (idle, `req_in` high, `ack_in` low), each bit whose two copies agree is copied into `q_out` at the next clock edge.
- R2: While the stage is evaluating, each bit whose two copies disagree keeps its previous `q_out` value.
- R3: When all bit pairs agree during evaluation, `wr_pulse` rises at the next edge and stays high for exactly `WR_CYC` cycles. No write starts on a word with any disagreeing pair.
- R4: `req_out` rises, and `ack_out` is high, only after the write pulse has ended. `ack_out` is high only while the two copies are equal.
- R5: When any bit pair disagrees during evaluation, `reread_req` is high for one cycle and `wr_pulse` and `ack_out` stay low. After the re-read cycle the stage evaluates again, and `q_out` does not change during the re-read cycle.
- R6: `miss_cnt` rises by one for each re-read event and saturates at 2^`CNT_W`-1. Reset and power-down clear it to zero.
- R7: The handshake returns to zero in four phases. `ack_out` and `req_out` stay high until `req_in` is low and `ack_in` is high. They then fall, and no new word is accepted until `ack_in` is low.
- R8: While `rst_n` is low or `pwr_dn` is high, `q_out` is zero. The first cycle after release has `rd_pulse` high for exactly one cycle, and in the next cycle `q_out` equals the last committed word.
- R9: `shunt_en` is high exactly when none of `wr_pulse`, `rd_pulse` and `reread_req` is high. A write is never active in the same cycle as a read or a re-read.
- R10: Storage changes only when a write pulse completes. A word whose copies disagree never reaches storage, and neither reset nor power-down alters storage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset event; clears volatile state only |
| pwr_dn | input | 1 | Power-down; clears volatile state only |
| req_in | input | 1 | Request from previous stage |
| dat_a | input | WIDTH | Primary data copy |
| dat_b | input | WIDTH | Duplicate data copy |
| ack_out | output | 1 | Acknowledge to previous stage |
| req_out | output | 1 | Request to next stage |
| ack_in | input | 1 | Acknowledge from next stage |
| q_out | output | WIDTH | C-element outputs |
| wr_pulse | output | 1 | Storage write in progress |
| rd_pulse | output | 1 | Storage sense in progress (restore) |
| reread_req | output | 1 | Re-read request to previous stage |
| shunt_en | output | 1 | Protect enable for storage, standby only |
| miss_cnt | output | CNT_W | Saturating count of re-read events |

## Verification
The hardest case to reach is a restore that must show that a disagreeing word never reached storage. The stage has to be left with a committed value, then given a disagreeing word that partly updates the C-elements, then reset while the re-read is still pending. The stimulus does this in that order, so the value restored after release must be the older committed word and not the partially updated C-element contents. The same sequence is repeated with power-down in place of reset. A full sweep over every pair of 4-bit copies, with the expected output computed per bit from the previous output, exercises each split between agreeing and disagreeing bits. The sweep also drives the mismatch counter well into saturation.

// File: rtl/nvstage_pkg.sv
package nvstage_pkg;
   typedef enum logic [2:0] {
      ST_OFF    = 3'd0,
      ST_SENSE  = 3'd1,
      ST_IDLE   = 3'd2,
      ST_WRITE  = 3'd3,
      ST_REREAD = 3'd4,
      ST_DONE   = 3'd5,
      ST_RTZ    = 3'd6
   } stage_st_e;
endpackage

// File: rtl/nvstage_muller_bank.sv
module nvstage_muller_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             load,
   input  logic [WIDTH-1:0] ld_val,
   input  logic             en,
   input  logic [WIDTH-1:0] in_a,
   input  logic [WIDTH-1:0] in_b,
   output logic [WIDTH-1:0] q
);
   for (genvar i = 0; i < WIDTH; i++) begin : g_cel
      logic q_bit;
      always_ff @(posedge clk) begin
         if (clr)
            q_bit <= 1'b0;
         else if (load)
            q_bit <= ld_val[i];
         else if (en && (in_a[i] == in_b[i]))
            q_bit <= in_a[i];
      end
      assign q[i] = q_bit;
   end
endmodule

// File: rtl/nvstage_store.sv
module nvstage_store #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             commit,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] cells;
   // no reset: contents persist through reset and power-down
   always_ff @(posedge clk) begin
      if (commit)
         cells <= din;
   end
   assign dout = cells;
endmodule

// File: rtl/nvstage_ctrl.sv
module nvstage_ctrl
   import nvstage_pkg::*;
#(
   parameter int WR_CYC = 3,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             req_in,
   input  logic             ack_in,
   input  logic             eq,
   output logic             eval,
   output logic             load,
   output logic             wr,
   output logic             commit,
   output logic             rd,
   output logic             reread,
   output logic             ack_out,
   output logic             req_out,
   output logic [CNT_W-1:0] miss_cnt
);
   localparam int CW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;
   localparam logic [CW-1:0] LAST = CW'(WR_CYC - 1);

   stage_st_e        st;
   logic [CW-1:0]    cnt;

   assign eval    = (st == ST_IDLE) && req_in && !ack_in;
   assign load    = (st == ST_SENSE);
   assign rd      = (st == ST_SENSE);
   assign wr      = (st == ST_WRITE);
   assign commit  = wr && (cnt == LAST);
   assign reread  = (st == ST_REREAD);
   assign req_out = (st == ST_DONE);
   assign ack_out = (st == ST_DONE) && eq;

   always_ff @(posedge clk) begin
      if (clr) begin
         st       <= ST_OFF;
         cnt      <= '0;
         miss_cnt <= '0;
      end else begin
         unique case (st)
            ST_OFF:   st <= ST_SENSE;
            ST_SENSE: st <= ST_IDLE;
            ST_IDLE: begin
               if (eval) begin
                  if (eq) begin
                     st  <= ST_WRITE;
                     cnt <= '0;
                  end else begin
                     st <= ST_REREAD;
                     if (miss_cnt != '1)
                        miss_cnt <= miss_cnt + 1'b1;
                  end
               end
            end
            ST_WRITE: begin
               if (cnt == LAST)
                  st <= ST_DONE;
               else
                  cnt <= cnt + 1'b1;
            end
            ST_REREAD: st <= ST_IDLE;
            ST_DONE: begin
               if (!req_in && ack_in)
                  st <= ST_RTZ;
            end
            ST_RTZ: begin
               if (!ack_in)
                  st <= ST_IDLE;
            end
            default: st <= ST_OFF;
         endcase
      end
   end
endmodule

// File: rtl/nvstage_top.sv
module nvstage_top #(
   parameter int WIDTH  = 8,
   parameter int WR_CYC = 3,
   parameter int CNT_W  = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwr_dn,
   input  logic             req_in,
   input  logic [WIDTH-1:0] dat_a,
   input  logic [WIDTH-1:0] dat_b,
   output logic             ack_out,
   output logic             req_out,
   input  logic             ack_in,
   output logic [WIDTH-1:0] q_out,
   output logic             wr_pulse,
   output logic             rd_pulse,
   output logic             reread_req,
   output logic             shunt_en,
   output logic [CNT_W-1:0] miss_cnt
);
   if (WIDTH < 1) begin : g_bad_width
      $error("WIDTH must be at least 1");
   end
   if (WR_CYC < 1) begin : g_bad_wrcyc
      $error("WR_CYC must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cntw
      $error("CNT_W must be at least 1");
   end

   logic             clr;
   logic             eq;
   logic             eval_s;
   logic             load_s;
   logic             commit_s;
   logic [WIDTH-1:0] stored;

   assign clr = !rst_n || pwr_dn;
   assign eq  = &(~(dat_a ^ dat_b));

   nvstage_ctrl #(.WR_CYC(WR_CYC), .CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .clr      (clr),
      .req_in   (req_in),
      .ack_in   (ack_in),
      .eq       (eq),
      .eval     (eval_s),
      .load     (load_s),
      .wr       (wr_pulse),
      .commit   (commit_s),
      .rd       (rd_pulse),
      .reread   (reread_req),
      .ack_out  (ack_out),
      .req_out  (req_out),
      .miss_cnt (miss_cnt)
   );

   nvstage_muller_bank #(.WIDTH(WIDTH)) u_cel (
      .clk    (clk),
      .clr    (clr),
      .load   (load_s),
      .ld_val (stored),
      .en     (eval_s),
      .in_a   (dat_a),
      .in_b   (dat_b),
      .q      (q_out)
   );

   nvstage_store #(.WIDTH(WIDTH)) u_nv (
      .clk    (clk),
      .commit (commit_s),
      .din    (q_out),
      .dout   (stored)
   );

   assign shunt_en = !(wr_pulse || rd_pulse || reread_req);
endmodule

// File: rtl/nvstage_chk.sv
module nvstage_chk #(
   parameter int WIDTH  = 8,
   parameter int WR_CYC = 3,
   parameter int CNT_W  = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_dn,
   input logic             eval_s,
   input logic [WIDTH-1:0] dat_a,
   input logic [WIDTH-1:0] dat_b,
   input logic [WIDTH-1:0] q_out,
   input logic             wr_pulse,
   input logic             rd_pulse,
   input logic             reread_req,
   input logic             ack_out,
   input logic             req_out,
   input logic [CNT_W-1:0] miss_cnt
);
   logic [15:0] wr_run;
   always_ff @(posedge clk) begin
      if (!rst_n || pwr_dn)
         wr_run <= '0;
      else if (wr_pulse)
         wr_run <= wr_run + 16'd1;
      else
         wr_run <= '0;
   end

   a_r1_copy_equal: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      eval_s && (dat_a == dat_b) |=> q_out == $past(dat_a));

   a_r2_hold_unequal: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      eval_s |=> ((q_out ^ $past(q_out)) & $past(dat_a ^ dat_b)) == '0);

   a_r3_write_agree: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      $rose(wr_pulse) |-> $past(dat_a == dat_b));

   a_r3_write_len: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      (!wr_pulse && $past(wr_pulse)) |-> wr_run == 16'(WR_CYC));

   a_r4_ack_agree: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      ack_out |-> dat_a == dat_b);

   a_r4_req_after_write: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      $rose(req_out) |-> $past(wr_pulse));

   a_r5_reread_mismatch: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      $rose(reread_req) |-> $past(dat_a != dat_b));

   a_r5_reread_single: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      reread_req |=> !reread_req);

   a_r6_cnt_monotone: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      1'b1 |=> miss_cnt >= $past(miss_cnt));

   a_r8_sense_single: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      rd_pulse |=> !rd_pulse);

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
      wr_pulse |-> !(rd_pulse || reread_req));
endmodule

bind nvstage_top nvstage_chk #(.WIDTH(WIDTH), .WR_CYC(WR_CYC), .CNT_W(CNT_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pwr_dn     (pwr_dn),
   .eval_s     (eval_s),
   .dat_a      (dat_a),
   .dat_b      (dat_b),
   .q_out      (q_out),
   .wr_pulse   (wr_pulse),
   .rd_pulse   (rd_pulse),
   .reread_req (reread_req),
   .ack_out    (ack_out),
   .req_out    (req_out),
   .miss_cnt   (miss_cnt)
);

// File: tb/tb_nvstage_top.sv
`timescale 1ns/1ps
module tb_nvstage_top;
   localparam int W   = 4;
   localparam int WRC = 3;
   localparam int CW  = 3;
   localparam int SAT = (1 << CW) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         pwr_dn = 1'b0;
   logic         req_in = 1'b0;
   logic [W-1:0] dat_a = '0;
   logic [W-1:0] dat_b = '0;
   logic         ack_in = 1'b0;
   logic         ack_out, req_out, wr_pulse, rd_pulse, reread_req, shunt_en;
   logic [W-1:0] q_out;
   logic [CW-1:0] miss_cnt;

   int total = 0;
   int bad   = 0;
   int misses = 0;
   logic [W-1:0] qm;
   logic [W-1:0] committed;

   always #5 clk = ~clk;

   nvstage_top #(.WIDTH(W), .WR_CYC(WRC), .CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .req_in(req_in),
      .dat_a(dat_a), .dat_b(dat_b), .ack_out(ack_out), .req_out(req_out),
      .ack_in(ack_in), .q_out(q_out), .wr_pulse(wr_pulse), .rd_pulse(rd_pulse),
      .reread_req(reread_req), .shunt_en(shunt_en), .miss_cnt(miss_cnt)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic int exp_miss();
      return (misses > SAT) ? SAT : misses;
   endfunction

   task automatic xact(input logic [W-1:0] a, input logic [W-1:0] b);
      logic [W-1:0] eq_m;
      logic [W-1:0] eq_q;
      eq_m = ~(a ^ b);
      dat_a = a; dat_b = b; req_in = 1'b1;
      step();
      eq_q = (a & eq_m) | (qm & ~eq_m);
      if (a == b)
         chk(q_out == eq_q, "R1 equal bits copied", q_out, eq_q);
      else
         chk(q_out == eq_q, "R2 unequal bits hold", q_out, eq_q);
      qm = eq_q;
      if (a != b) begin
         misses++;
         chk(reread_req == 1'b1, "R5 reread pulse", reread_req, 1);
         chk(wr_pulse == 1'b0, "R5 no write on mismatch", wr_pulse, 0);
         chk(ack_out == 1'b0, "R5 no ack on mismatch", ack_out, 0);
         chk(shunt_en == 1'b0, "R9 shunt off during reread", shunt_en, 0);
         chk(miss_cnt == CW'(exp_miss()), "R6 miss count", miss_cnt, exp_miss());
         dat_b = a;
         step();
         chk(reread_req == 1'b0, "R5 reread one cycle", reread_req, 0);
         chk(q_out == qm, "R5 q stable in reread", q_out, qm);
         step();
         chk(q_out == a, "R1 reevaluated copy", q_out, a);
      end
      for (int i = 0; i < WRC; i++) begin
         chk(wr_pulse == 1'b1, "R3 write pulse", wr_pulse, 1);
         chk(shunt_en == 1'b0, "R9 shunt off during write", shunt_en, 0);
         chk(ack_out == 1'b0 && req_out == 1'b0, "R4 no ack during write", ack_out, 0);
         step();
      end
      chk(wr_pulse == 1'b0, "R3 write length", wr_pulse, 0);
      chk(ack_out == 1'b1 && req_out == 1'b1, "R4 ack after write", ack_out, 1);
      chk(shunt_en == 1'b1, "R9 shunt in standby", shunt_en, 1);
      qm = a;
      committed = a;
      req_in = 1'b0;
      step();
      chk(ack_out == 1'b1 && req_out == 1'b1, "R7 hold until ack_in", req_out, 1);
      ack_in = 1'b1;
      step();
      chk(ack_out == 1'b0 && req_out == 1'b0, "R7 return to zero", req_out, 0);
      dat_a = ~a; dat_b = ~a; req_in = 1'b1;
      step();
      chk(q_out == qm && wr_pulse == 1'b0, "R7 no accept while ack_in high", q_out, qm);
      req_in = 1'b0; dat_a = a; dat_b = a;
      ack_in = 1'b0;
      step();
   endtask

   task automatic restore_check(input bit use_pwr);
      xact(4'hA, 4'hA);
      dat_a = 4'h5; dat_b = 4'h6; req_in = 1'b1;
      step();
      chk(reread_req == 1'b1, "R5 reread before reset", reread_req, 1);
      req_in = 1'b0;
      if (use_pwr) pwr_dn = 1'b1; else rst_n = 1'b0;
      step();
      step();
      chk(q_out == '0, "R8 q cleared while held", q_out, 0);
      chk(miss_cnt == '0, "R6 count cleared", miss_cnt, 0);
      chk(shunt_en == 1'b1 && rd_pulse == 1'b0, "R9 shunt while off", shunt_en, 1);
      if (use_pwr) pwr_dn = 1'b0; else rst_n = 1'b1;
      step();
      chk(rd_pulse == 1'b1, "R8 sense pulse", rd_pulse, 1);
      chk(shunt_en == 1'b0, "R9 shunt off during sense", shunt_en, 0);
      step();
      chk(rd_pulse == 1'b0, "R8 sense one cycle", rd_pulse, 0);
      chk(q_out == committed, "R10 restored committed word", q_out, committed);
      qm = q_out;
      misses = 0;
   endtask

   initial begin
      #2_000_000;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      qm = '0;
      committed = '0;
      @(negedge clk);
      step();
      step();
      chk(ack_out == 1'b0 && req_out == 1'b0, "R8 reset outputs idle", ack_out, 0);
      chk(wr_pulse == 1'b0 && reread_req == 1'b0, "R9 no activity in reset", wr_pulse, 0);
      chk(shunt_en == 1'b1, "R9 shunt in reset", shunt_en, 1);
      chk(miss_cnt == '0, "R6 count reset", miss_cnt, 0);
      chk(q_out == '0, "R8 q zero in reset", q_out, 0);
      rst_n = 1'b1;
      step();
      chk(rd_pulse == 1'b1, "R8 initial sense", rd_pulse, 1);
      step();
      for (int a = 0; a < (1 << W); a++) begin
         for (int b = 0; b < (1 << W); b++) begin
            xact(W'(a), W'(b));
         end
      end
      chk(miss_cnt == CW'(SAT), "R6 saturated", miss_cnt, SAT);
      restore_check(1'b0);
      restore_check(1'b1);
      xact(4'h3, 4'h3);
      chk(committed == 4'h3 && q_out == 4'h3, "R10 commit after restore", q_out, 3);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule